// File: doc/BRIEF.md
# Silhouette Correlation Element Array

This block scores one row of candidate positions against a binary silhouette template. The template has two masks that never overlap: a bright mask and a surround mask. There is one processing element per candidate column. Each template cell arrives as a shared 2-bit mask code, together with one pixel byte for every element. All elements consume the same cell in the same cycle.

Each template is processed in two passes over all of its cells.

1. In the first pass, every element totals its pixels that fall under the bright mask. Elements whose total falls outside a window are rejected.
2. Between the passes, one shared sequential divider visits the elements in order. For each it turns the total into a threshold: the mean bright level minus a per-template bias.
3. In the second pass, the surviving elements count two things at once. They count bright-mask pixels that reach the threshold, and surround-mask pixels that fall below it.

A controller upstream supplies the template settings with a start pulse. It then streams the cells twice, waiting for a done pulse before it reads the per-element results. A position scores as a hit when both counts exceed their minimums.

Top module: `sil_pe_array`

## Requirements
- R1: In the first pass, each element adds its pixel for every cell whose code is 2'b01 (bright) into a 16-bit total that saturates at 65535, presented on `sum_out`.
- R2: An element is rejected when its total is below `min_sum` or above `max_sum`; a total equal to either bound is kept. A rejected element keeps both counts at zero and never reports a hit.
- R3: The threshold is floor(total / B) minus `bias`, clamped to zero. B is the number of bright cells in the template, and B of zero gives a quotient of zero. Each threshold holds steady throughout the counting pass.
- R4: In the second pass, a kept element counts bright cells (code 2'b01) whose pixel is greater than or equal to its threshold. In the same pass it counts surround cells (code 2'b10) whose pixel is below it. Both counts are 8 bits, saturate at 255 and never decrease within a run.
- R5: `hit` for an element is set when the element is kept, its bright count is strictly greater than `min_bright` and its surround count is strictly greater than `min_surr`.
- R6: Cells coded 2'b00 or 2'b11 change no total and no count. Cells coded 2'b11 are left out of B.
- R7: `cell_rdy` is high only while a pass is open, and each pass accepts exactly 1024 cells (32 by 32). A cycle with `cell_valid` low consumes no cell.
- R8: Between the last accepted cell of the first pass and the opening of the second, `cell_rdy` stays low for NUM_PE*(16+2)+1 cycles (379 by default). This gap is spent serving each element with a 16-cycle restoring division.
- R9: `done` is a one-cycle pulse, seen two cycles after the last cell of the second pass is accepted. `busy` is low from that cycle on, and all results hold until the next accepted start.
- R10: All template settings are captured when a start is accepted while idle. A start that arrives while busy is ignored, and so are later changes to the settings inputs.
- R11: After reset, `busy`, `done`, `cell_rdy`, all totals, thresholds, counts, reject flags and hits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a template run when idle |
| min_sum | input | 16 | Lowest acceptable bright total |
| max_sum | input | 16 | Highest acceptable bright total |
| bias | input | 8 | Amount taken off the mean bright level |
| min_bright | input | 8 | Bright count must exceed this for a hit |
| min_surr | input | 8 | Surround count must exceed this for a hit |
| cell_valid | input | 1 | A cell is offered this cycle |
| cell_code | input | 2 | Mask code of the offered cell |
| cell_pix | input | NUM_PE*8 | One pixel byte per element, element 0 in the low byte |
| cell_rdy | output | 1 | A pass is open and cells are accepted |
| busy | output | 1 | A template run is in progress |
| done | output | 1 | One-cycle pulse when results are final |
| sum_out | output | NUM_PE*16 | Bright totals per element |
| thr_out | output | NUM_PE*8 | Thresholds per element |
| bright_cnt | output | NUM_PE*8 | Bright counts per element |
| surr_cnt | output | NUM_PE*8 | Surround counts per element |
| reject | output | NUM_PE | Element failed the total window |
| hit | output | NUM_PE | Element scored a hit |

## Verification
The bench places the total window exactly on the totals of two elements. A design that used inclusive rejection would then drop those elements, and an off-by-one threshold compare would miscount the bright and surround pixels that sit right on it. A bias larger than any mean, a template with no bright cells, and an all-white template that drives both the total and the bright counter into saturation cover the cases that would otherwise wrap, divide by zero or go negative. Gaps in `cell_valid`, illegal codes, and a stray start with settings changed mid-run show that a design which consumed idle cycles, counted code 2'b11, or re-latched its settings would produce wrong totals. The gap between passes and the done timing are counted cycle by cycle, so a divider that ran one step short or long would be caught.

// File: rtl/sil_pkg.sv
package sil_pkg;

    typedef enum logic [1:0] {
        CELL_NONE   = 2'b00,
        CELL_BRIGHT = 2'b01,
        CELL_SURR   = 2'b10,
        CELL_BAD    = 2'b11
    } cell_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_SETTLE,
        ST_DLOAD,
        ST_DWAIT,
        ST_CNT,
        ST_FLUSH
    } ctrl_state_e;

    // Cell as seen by every element one cycle after acceptance
    typedef struct packed {
        logic       v;
        logic       cnt_pass;
        cell_code_e code;
    } stage_t;

endpackage

// File: rtl/sil_div.sv
module sil_div #(
    parameter int DVD_W = 16,
    parameter int DVS_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             fin,
    output logic [DVD_W-1:0] quot
);
    localparam int STEP_W = (DVD_W > 1) ? $clog2(DVD_W) : 1;

    logic [DVS_W-1:0]  rem_q;
    logic [DVD_W-1:0]  quo_q;
    logic [DVS_W-1:0]  dvs_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic [DVS_W:0]    trial;
    logic [DVS_W:0]    diff;
    logic              fits;

    // One restoring step: bring down the next dividend bit, try the subtract
    always_comb begin
        trial = {rem_q, quo_q[DVD_W-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = trial >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dvs_q  <= divisor;
                step_q <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
                quo_q  <= {quo_q[DVD_W-2:0], fits};
                step_q <= step_q + STEP_W'(1);
                if (step_q == STEP_W'(DVD_W - 1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quot = (dvs_q == '0) ? '0 : quo_q;

endmodule

// File: rtl/sil_ctrl.sv
module sil_ctrl
    import sil_pkg::*;
#(
    parameter int NUM_PE = 21,
    parameter int CELLS  = 1024,
    parameter int NB_W   = 11,
    parameter int IDX_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cell_valid,
    input  logic [1:0]       cell_code,
    input  logic             div_fin,
    output logic             cell_rdy,
    output logic             busy,
    output logic             done,
    output logic             clr,
    output logic             take,
    output stage_t           stg,
    output logic [NB_W-1:0]  nb,
    output logic [IDX_W-1:0] pe_sel,
    output logic             div_go,
    output logic             thr_we
);
    localparam int CELL_W = (CELLS > 1) ? $clog2(CELLS) : 1;

    ctrl_state_e       state;
    logic [CELL_W-1:0] cell_cnt;
    logic              last_cell;

    assign cell_rdy  = (state == ST_SUM) || (state == ST_CNT);
    assign take      = cell_valid && cell_rdy;
    assign clr       = start && (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign div_go    = (state == ST_DLOAD);
    assign thr_we    = (state == ST_DWAIT) && div_fin;
    assign last_cell = (cell_cnt == CELL_W'(CELLS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cell_cnt <= '0;
            nb       <= '0;
            pe_sel   <= '0;
            done     <= 1'b0;
            stg      <= '0;
        end else begin
            done         <= 1'b0;
            stg.v        <= take;
            stg.cnt_pass <= (state == ST_CNT);
            stg.code     <= cell_code_e'(cell_code);
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SUM;
                        cell_cnt <= '0;
                        nb       <= '0;
                    end
                end
                ST_SUM: begin
                    if (take) begin
                        if (cell_code_e'(cell_code) == CELL_BRIGHT) nb <= nb + NB_W'(1);
                        if (last_cell) begin
                            cell_cnt <= '0;
                            state    <= ST_SETTLE;
                        end else begin
                            cell_cnt <= cell_cnt + CELL_W'(1);
                        end
                    end
                end
                ST_SETTLE: begin
                    pe_sel <= '0;
                    state  <= ST_DLOAD;
                end
                ST_DLOAD: state <= ST_DWAIT;
                ST_DWAIT: begin
                    if (div_fin) begin
                        if (pe_sel == IDX_W'(NUM_PE - 1)) begin
                            state <= ST_CNT;
                        end else begin
                            pe_sel <= pe_sel + IDX_W'(1);
                            state  <= ST_DLOAD;
                        end
                    end
                end
                ST_CNT: begin
                    if (take) begin
                        if (last_cell) begin
                            cell_cnt <= '0;
                            state    <= ST_FLUSH;
                        end else begin
                            cell_cnt <= cell_cnt + CELL_W'(1);
                        end
                    end
                end
                ST_FLUSH: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sil_pe.sv
module sil_pe
    import sil_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic [PIX_W-1:0] pix_in,
    input  stage_t           stg,
    input  logic [SUM_W-1:0] min_sum,
    input  logic [SUM_W-1:0] max_sum,
    input  logic [PIX_W-1:0] bias,
    input  logic             thr_we,
    input  logic [SUM_W-1:0] quot,
    output logic [SUM_W-1:0] sum_q,
    output logic [PIX_W-1:0] thr_q,
    output logic [CNT_W-1:0] bcnt_q,
    output logic [CNT_W-1:0] scnt_q,
    output logic             rej
);
    localparam int PAD = SUM_W + 1 - PIX_W;

    logic [PIX_W-1:0] pix_q;
    logic [SUM_W:0]   sum_ext;
    logic [SUM_W:0]   qx, bx, dx;
    logic [PIX_W-1:0] thr_next;
    logic             at_or_above;
    logic             acc_en, cnt_en;

    assign rej         = (sum_q < min_sum) || (sum_q > max_sum);
    assign sum_ext     = {1'b0, sum_q} + {{PAD{1'b0}}, pix_q};
    assign at_or_above = (pix_q >= thr_q);
    assign acc_en      = stg.v && !stg.cnt_pass && (stg.code == CELL_BRIGHT);
    assign cnt_en      = stg.v && stg.cnt_pass && !rej;

    // Mean minus bias, clamped into the pixel range
    always_comb begin
        qx = {1'b0, quot};
        bx = {{PAD{1'b0}}, bias};
        dx = qx - bx;
        if (qx < bx)
            thr_next = '0;
        else if (dx > {{PAD{1'b0}}, {PIX_W{1'b1}}})
            thr_next = '1;
        else
            thr_next = dx[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else if (take) begin
            pix_q <= pix_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q  <= '0;
            thr_q  <= '0;
            bcnt_q <= '0;
            scnt_q <= '0;
        end else begin
            if (acc_en) sum_q <= sum_ext[SUM_W] ? '1 : sum_ext[SUM_W-1:0];
            if (thr_we) thr_q <= thr_next;
            if (cnt_en) begin
                if (stg.code == CELL_BRIGHT && at_or_above && bcnt_q != '1)
                    bcnt_q <= bcnt_q + CNT_W'(1);
                if (stg.code == CELL_SURR && !at_or_above && scnt_q != '1)
                    scnt_q <= scnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sil_pe_array.sv
module sil_pe_array
    import sil_pkg::*;
#(
    parameter int NUM_PE   = 21,
    parameter int PIX_W    = 8,
    parameter int SUM_W    = 16,
    parameter int CNT_W    = 8,
    parameter int TPL_ROWS = 32,
    parameter int TPL_COLS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [SUM_W-1:0]        min_sum,
    input  logic [SUM_W-1:0]        max_sum,
    input  logic [PIX_W-1:0]        bias,
    input  logic [CNT_W-1:0]        min_bright,
    input  logic [CNT_W-1:0]        min_surr,
    input  logic                    cell_valid,
    input  logic [1:0]              cell_code,
    input  logic [NUM_PE*PIX_W-1:0] cell_pix,
    output logic                    cell_rdy,
    output logic                    busy,
    output logic                    done,
    output logic [NUM_PE*SUM_W-1:0] sum_out,
    output logic [NUM_PE*PIX_W-1:0] thr_out,
    output logic [NUM_PE*CNT_W-1:0] bright_cnt,
    output logic [NUM_PE*CNT_W-1:0] surr_cnt,
    output logic [NUM_PE-1:0]       reject,
    output logic [NUM_PE-1:0]       hit
);
    localparam int CELLS = TPL_ROWS * TPL_COLS;
    localparam int NB_W  = $clog2(CELLS + 1);
    localparam int IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

    logic             clr, take, div_go, div_fin, thr_we;
    stage_t           stg;
    logic [NB_W-1:0]  nb;
    logic [IDX_W-1:0] pe_sel;
    logic [SUM_W-1:0] quot;
    logic [SUM_W-1:0] min_sum_q, max_sum_q;
    logic [PIX_W-1:0] bias_q;
    logic [CNT_W-1:0] minb_q, mins_q;
    logic [SUM_W-1:0] sum_arr [NUM_PE];

    always_ff @(posedge clk) begin
        if (rst) begin
            min_sum_q <= '0;
            max_sum_q <= '0;
            bias_q    <= '0;
            minb_q    <= '0;
            mins_q    <= '0;
        end else if (clr) begin
            min_sum_q <= min_sum;
            max_sum_q <= max_sum;
            bias_q    <= bias;
            minb_q    <= min_bright;
            mins_q    <= min_surr;
        end
    end

    sil_ctrl #(
        .NUM_PE(NUM_PE), .CELLS(CELLS), .NB_W(NB_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .cell_valid(cell_valid), .cell_code(cell_code), .div_fin(div_fin),
        .cell_rdy(cell_rdy), .busy(busy), .done(done), .clr(clr), .take(take),
        .stg(stg), .nb(nb), .pe_sel(pe_sel), .div_go(div_go), .thr_we(thr_we)
    );

    sil_div #(
        .DVD_W(SUM_W), .DVS_W(NB_W)
    ) u_div (
        .clk(clk), .rst(rst), .go(div_go),
        .dividend(sum_arr[pe_sel]), .divisor(nb),
        .fin(div_fin), .quot(quot)
    );

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        logic [PIX_W-1:0] thr_i;
        logic [CNT_W-1:0] bcnt_i, scnt_i;
        logic             rej_i;

        sil_pe #(
            .PIX_W(PIX_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
        ) u_pe (
            .clk(clk), .rst(rst), .clr(clr), .take(take),
            .pix_in(cell_pix[i*PIX_W +: PIX_W]), .stg(stg),
            .min_sum(min_sum_q), .max_sum(max_sum_q), .bias(bias_q),
            .thr_we(thr_we && (pe_sel == IDX_W'(i))), .quot(quot),
            .sum_q(sum_arr[i]), .thr_q(thr_i),
            .bcnt_q(bcnt_i), .scnt_q(scnt_i), .rej(rej_i)
        );

        assign sum_out[i*SUM_W +: SUM_W]    = sum_arr[i];
        assign thr_out[i*PIX_W +: PIX_W]    = thr_i;
        assign bright_cnt[i*CNT_W +: CNT_W] = bcnt_i;
        assign surr_cnt[i*CNT_W +: CNT_W]   = scnt_i;
        assign reject[i]                    = rej_i;
        assign hit[i] = !rej_i && (bcnt_i > minb_q) && (scnt_i > mins_q);
    end

endmodule

// File: rtl/sil_pe_array_chk.sv
module sil_pe_array_chk #(
    parameter int NUM_PE = 21,
    parameter int PIX_W  = 8,
    parameter int SUM_W  = 16,
    parameter int CNT_W  = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    cell_rdy,
    input logic                    busy,
    input logic                    done,
    input logic [NUM_PE*SUM_W-1:0] sum_out,
    input logic [NUM_PE*PIX_W-1:0] thr_out,
    input logic [NUM_PE*CNT_W-1:0] bright_cnt,
    input logic [NUM_PE*CNT_W-1:0] surr_cnt
);

    AST_RDY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cell_rdy |-> busy);  // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R9

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);  // R9

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum_out) && $stable(thr_out)
                               && $stable(bright_cnt) && $stable(surr_cnt)));  // R9

    AST_BUSY_START_KEEP: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy);  // R10

    AST_THR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (cell_rdy && $past(cell_rdy)) |-> $stable(thr_out));  // R3

    for (genvar i = 0; i < NUM_PE; i++) begin : g_mono
        AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
            (busy && $past(busy)) |->
                (bright_cnt[i*CNT_W +: CNT_W] >= $past(bright_cnt[i*CNT_W +: CNT_W])
                 && surr_cnt[i*CNT_W +: CNT_W] >= $past(surr_cnt[i*CNT_W +: CNT_W])));  // R4
    end

endmodule

bind sil_pe_array sil_pe_array_chk #(
    .NUM_PE(NUM_PE), .PIX_W(PIX_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .cell_rdy(cell_rdy), .busy(busy),
    .done(done), .sum_out(sum_out), .thr_out(thr_out),
    .bright_cnt(bright_cnt), .surr_cnt(surr_cnt)
);

// File: tb/sil_pe_array_test.sv
module sil_pe_array_test;
    localparam int NUM_PE = 21;
    localparam int PIX_W  = 8;
    localparam int SUM_W  = 16;
    localparam int CNT_W  = 8;
    localparam int CELLS  = 1024;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic [SUM_W-1:0]        min_sum = '0, max_sum = '0;
    logic [PIX_W-1:0]        bias = '0;
    logic [CNT_W-1:0]        min_bright = '0, min_surr = '0;
    logic                    cell_valid = 1'b0;
    logic [1:0]              cell_code = '0;
    logic [NUM_PE*PIX_W-1:0] cell_pix = '0;
    logic                    cell_rdy, busy, done;
    logic [NUM_PE*SUM_W-1:0] sum_out;
    logic [NUM_PE*PIX_W-1:0] thr_out;
    logic [NUM_PE*CNT_W-1:0] bright_cnt, surr_cnt;
    logic [NUM_PE-1:0]       reject, hit;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sil_pe_array uut (
        .clk(clk), .rst(rst), .start(start), .min_sum(min_sum), .max_sum(max_sum),
        .bias(bias), .min_bright(min_bright), .min_surr(min_surr),
        .cell_valid(cell_valid), .cell_code(cell_code), .cell_pix(cell_pix),
        .cell_rdy(cell_rdy), .busy(busy), .done(done), .sum_out(sum_out),
        .thr_out(thr_out), .bright_cnt(bright_cnt), .surr_cnt(surr_cnt),
        .reject(reject), .hit(hit)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned mix(int unsigned s, int unsigned p, int unsigned c);
        int unsigned x;
        x = (s * 32'h9E3779B9) ^ (p * 32'h85EBCA6B) ^ (c * 32'hC2B2AE35);
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        return x;
    endfunction

    // Mode 0: mixed template, mode 1: all bright and white, mode 2: no bright cells
    function automatic int code_of(int mode, int c);
        int r;
        if (mode == 1) return 1;
        r = int'(mix(91, 0, c) % 100);
        if (mode == 0) begin
            if (r < 9)  return 1;
            if (r < 18) return 2;
            if (r < 20) return 3;
            return 0;
        end
        if (r < 10) return 2;
        if (r < 13) return 3;
        return 0;
    endfunction

    function automatic int pix_of(int mode, int seed, int p, int c);
        if (mode == 1) return 255;
        return int'(mix(seed, p, c) % (96 + 6 * p)) + p;
    endfunction

    function automatic int exp_sum(int mode, int seed, int p);
        int s = 0;
        for (int c = 0; c < CELLS; c++)
            if (code_of(mode, c) == 1) s += pix_of(mode, seed, p, c);
        return (s > 65535) ? 65535 : s;
    endfunction

    task automatic run_tpl(input int mode, input int seed, input int bv, input int mn,
                           input int mx, input int mb, input int ms, input bit gaps,
                           input bit inject, input string name);
        int nb = 0;
        int e_sum[NUM_PE], e_thr[NUM_PE], e_bc[NUM_PE], e_sc[NUM_PE];
        int e_rej[NUM_PE], e_hit[NUM_PE];
        int k;
        for (int c = 0; c < CELLS; c++) if (code_of(mode, c) == 1) nb++;
        for (int p = 0; p < NUM_PE; p++) begin
            int q;
            e_sum[p] = exp_sum(mode, seed, p);
            e_rej[p] = (e_sum[p] < mn || e_sum[p] > mx) ? 1 : 0;
            q = (nb == 0) ? 0 : e_sum[p] / nb;
            e_thr[p] = (q - bv < 0) ? 0 : q - bv;
            e_bc[p] = 0;
            e_sc[p] = 0;
            if (e_rej[p] == 0) begin
                for (int c = 0; c < CELLS; c++) begin
                    int cd = code_of(mode, c);
                    int px = pix_of(mode, seed, p, c);
                    if (cd == 1 && px >= e_thr[p] && e_bc[p] < 255) e_bc[p]++;
                    if (cd == 2 && px < e_thr[p] && e_sc[p] < 255) e_sc[p]++;
                end
            end
            e_hit[p] = (e_rej[p] == 0 && e_bc[p] > mb && e_sc[p] > ms) ? 1 : 0;
        end

        @(negedge clk);
        start = 1'b1;
        min_sum = SUM_W'(mn); max_sum = SUM_W'(mx); bias = PIX_W'(bv);
        min_bright = CNT_W'(mb); min_surr = CNT_W'(ms);
        @(negedge clk);
        start = 1'b0;
        // R10: settings inputs change after the start is taken
        min_sum = '1; max_sum = '0; bias = 8'd77; min_bright = '1; min_surr = '1;

        for (int ph = 0; ph < 2; ph++) begin
            int n = 0;
            int cyc = 0;
            while (n < CELLS) begin
                bit v;
                chk(int'(cell_rdy), 1, {name, " R7 pass open"});
                v = !(gaps && (cyc % 7 == 3));
                cell_valid = v;
                cell_code = 2'(code_of(mode, n));
                for (int p = 0; p < NUM_PE; p++)
                    cell_pix[p*PIX_W +: PIX_W] = PIX_W'(pix_of(mode, seed, p, n));
                start = inject && (ph == 0) && (cyc == 150);  // R10 ignored start
                @(negedge clk);
                start = 1'b0;
                if (v) n++;
                cyc++;
            end
            cell_valid = 1'b0;
            if (ph == 0) begin
                k = 0;
                while (!cell_rdy && k < 2000) begin
                    k++;
                    @(negedge clk);
                end
                chk(k, NUM_PE * (SUM_W + 2) + 1, {name, " R8 divide gap"});
            end else begin
                chk(int'(done), 0, {name, " R9 done early"});
                chk(int'(busy), 1, {name, " R9 busy before done"});
                @(negedge clk);
                chk(int'(done), 1, {name, " R9 done pulse"});
                chk(int'(busy), 0, {name, " R9 busy low at done"});
                @(negedge clk);
                chk(int'(done), 0, {name, " R9 done one cycle"});
                chk(int'(cell_rdy), 0, {name, " R7 closed after run"});
            end
        end

        for (int p = 0; p < NUM_PE; p++) begin
            chk(int'(sum_out[p*SUM_W +: SUM_W]), e_sum[p], {name, " R1 R6 total"});
            chk(int'(reject[p]), e_rej[p], {name, " R2 reject"});
            chk(int'(thr_out[p*PIX_W +: PIX_W]), e_thr[p], {name, " R3 threshold"});
            chk(int'(bright_cnt[p*CNT_W +: CNT_W]), e_bc[p], {name, " R4 bright count"});
            chk(int'(surr_cnt[p*CNT_W +: CNT_W]), e_sc[p], {name, " R4 surround count"});
            chk(int'(hit[p]), e_hit[p], {name, " R5 hit"});
        end
        repeat (5) @(negedge clk);
        chk(int'(bright_cnt[CNT_W-1:0]), e_bc[0], {name, " R9 results hold"});
        chk(int'(sum_out[SUM_W-1:0]), e_sum[0], {name, " R9 total holds"});
    endtask

    initial begin
        int s3, s17;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(int'(busy), 0, "R11 busy");
        chk(int'(done), 0, "R11 done");
        chk(int'(cell_rdy), 0, "R11 cell_rdy");
        chk(int'(sum_out == '0), 1, "R11 totals");
        chk(int'(thr_out == '0), 1, "R11 thresholds");
        chk(int'((bright_cnt == '0) && (surr_cnt == '0)), 1, "R11 counts");
        chk(int'(reject), 0, "R11 reject");
        chk(int'(hit), 0, "R11 hit");

        // R2 window set exactly on two element totals; gaps and stray start
        s3  = exp_sum(0, 5, 3);
        s17 = exp_sum(0, 5, 17);
        run_tpl(0, 5, 6, (s3 < s17) ? s3 : s17, (s3 < s17) ? s17 : s3,
                40, 40, 1'b1, 1'b1, "mixed");
        // R3 bias beyond every mean: threshold clamps to zero
        run_tpl(0, 9, 255, 0, 65535, 0, 0, 1'b0, 1'b0, "clamp");
        // R3 no bright cells: quotient zero; R6 illegal codes present
        run_tpl(2, 3, 0, 0, 65535, 0, 0, 1'b1, 1'b0, "nobright");
        // R1 R4 saturation of total and bright count
        run_tpl(1, 1, 3, 0, 65535, 254, 0, 1'b0, 1'b0, "saturate");
        // R2 tight upper bound rejects
        run_tpl(0, 11, 0, 1, 100, 0, 0, 1'b0, 1'b0, "upper");

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule